// File: doc/BRIEF.md
# Compressed Data Host Width Adapter

This block sits between a codec core and a host that moves compressed data through one memory-mapped data register. When encoding, the core hands over a byte stream and the host pulls it out by reading the register. When decoding, the host writes the register and the block feeds bytes to the core. Transfers are either one byte per access on the DATA lane, or two bytes per access with the CODE lane acting as an extension of DATA. A byte-order bit chooses which lane carries the byte that comes first in the stream.

The block keeps the bytes in a small buffer between the two sides. On the encode side it pads a lone final byte with a fill value in wide mode. On the decode side it drops the filler byte of a short final word when the core ends the stream. Host accesses that cannot be served leave the buffer and the host outputs untouched and set a sticky error flag. The mode and lane configuration are held steady while out of reset. A host access is a one-cycle strobe on `host_rd` or `host_wr`.

Top module: `cdx_width_adapter`

## Requirements
- R1: After reset both host output lanes read 0x00, both error flags are 0, `core_out_valid` is 0, and `core_in_ready` is 1 in encode mode (`cfg_decode`=0).
- R2: Narrow encode (`cfg_wide`=0): each host read returns the next stream byte on `host_data_out` and 0x00 on `host_code_out`, visible one cycle after the read strobe.
- R3: Wide encode: each host read returns two stream bytes. The earlier byte is on `host_data_out` when `cfg_code_first`=0 and on `host_code_out` when `cfg_code_first`=1. The later byte is on the other lane.
- R4: Wide encode: when the oldest buffered byte was tagged with `core_in_last`, a read returns it alone, with 0xFF on the other lane, and removes only that byte.
- R5: A read in encode mode with no complete word buffered sets `err_underrun`, which stays 1 until reset, and leaves the host outputs and the buffer unchanged. A complete word is one byte in narrow mode, and in wide mode either two bytes or a single byte tagged last.
- R6: Narrow decode: each host write delivers `host_data_in` to the core in order. `host_code_in` is ignored.
- R7: Wide decode: each host write delivers two bytes. The earlier byte is taken from `host_data_in` when `cfg_code_first`=0 and from `host_code_in` when it is 1.
- R8: When the core accepts a byte with `core_out_end`=1, every byte still buffered is discarded, so a filler byte never reaches the core.
- R9: A write in decode mode without room for all its bytes sets `err_overrun`, which stays 1 until reset, and stores none of them.
- R10: The buffer holds at most DEPTH bytes. `core_in_ready` is 0 when it is full in encode mode, and `core_out_valid` is 0 when it is empty.
- R11: `host_wr` has no effect in encode mode, and `host_rd` has no effect in decode mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_decode | input | 1 | 0: encode (host reads), 1: decode (host writes) |
| cfg_wide | input | 1 | 1: two bytes per host access |
| cfg_code_first | input | 1 | 1: earlier byte travels on the CODE lane |
| host_rd | input | 1 | One-cycle read strobe of the data register |
| host_wr | input | 1 | One-cycle write strobe of the data register |
| host_data_in | input | 8 | DATA lane write data |
| host_code_in | input | 8 | CODE lane write data |
| host_data_out | output | 8 | DATA lane read data, registered |
| host_code_out | output | 8 | CODE lane read data, registered |
| core_in_valid | input | 1 | Encode byte from core is valid |
| core_in_ready | output | 1 | Adapter can take an encode byte |
| core_in_byte | input | 8 | Encode byte |
| core_in_last | input | 1 | Encode byte is the last of its stream |
| core_out_valid | output | 1 | Decode byte available to core |
| core_out_ready | input | 1 | Core takes the decode byte |
| core_out_byte | output | 8 | Decode byte |
| core_out_end | input | 1 | With a taken byte: stream ends, flush remainder |
| err_underrun | output | 1 | Sticky: read with no word ready |
| err_overrun | output | 1 | Sticky: write with no room |

## Verification
The bench targets the lane swap under both byte orders. A design that ignored the order bit would return the two bytes exchanged. It also targets the lone last byte in wide mode: a wrong design would either stall with an underrun or take the next stream's first byte instead of placing 0xFF. Reads and writes that arrive too early are aimed at data corruption, where a faulty block would pop half a word or store part of a write. The stream-end flush is checked so that a junk filler byte never shows up at the core, and a random mixed phase compares every output each cycle against a queue model.

// File: rtl/cdx_pkg.sv
package cdx_pkg;

   // One buffered byte with its end-of-stream tag.
   typedef struct packed {
      logic       last;
      logic [7:0] data;
   } cdx_entry_t;

   typedef enum logic {
      CDX_ENCODE = 1'b0,
      CDX_DECODE = 1'b1
   } cdx_dir_e;

endpackage

// File: rtl/cdx_byte_fifo.sv
module cdx_byte_fifo
   import cdx_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      push_n,
   input  cdx_entry_t      push0,
   input  cdx_entry_t      push1,
   input  logic [1:0]      pop_n,
   input  logic            flush,
   output cdx_entry_t      head0,
   output cdx_entry_t      head1,
   output logic [CW-1:0]   count
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("cdx_byte_fifo: DEPTH must be a power of two, at least 2");
   end

   cdx_entry_t    mem [DEPTH];
   logic [AW-1:0] rd_ptr, wr_ptr, rd_nx, wr_nx;

   assign rd_nx = rd_ptr + AW'(1);
   assign wr_nx = wr_ptr + AW'(1);
   assign head0 = mem[rd_ptr];
   assign head1 = mem[rd_nx];

   always_ff @(posedge clk) begin
      if (push_n != 2'd0) mem[wr_ptr] <= push0;
      if (push_n == 2'd2) mem[wr_nx]  <= push1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         wr_ptr <= wr_ptr + AW'(push_n);
         if (flush) begin
            // remainder is dropped; only this cycle's push survives
            rd_ptr <= wr_ptr;
            count  <= CW'(push_n);
         end else begin
            rd_ptr <= rd_ptr + AW'(pop_n);
            count  <= count - CW'(pop_n) + CW'(push_n);
         end
      end
   end

   // R5: never remove more bytes than are held
   p_pop_le_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      CW'(pop_n) <= count);

   // R10: occupancy never exceeds the storage
   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush) |-> (int'(count) - int'(pop_n) + int'(push_n) <= DEPTH));

endmodule

// File: rtl/cdx_lane_pack.sv
module cdx_lane_pack
   import cdx_pkg::*;
#(
   parameter logic [7:0] PAD_BYTE    = 8'hFF,
   parameter logic [7:0] NARROW_FILL = 8'h00
) (
   input  logic       wide,
   input  logic       code_first,
   input  cdx_entry_t head0,
   input  cdx_entry_t head1,
   input  logic       have1,
   input  logic       have2,
   output logic       word_ok,
   output logic [1:0] pop_n,
   output logic [7:0] lane_data,
   output logic [7:0] lane_code
);

   logic [7:0] early_b, late_b;

   always_comb begin
      early_b = head0.data;
      late_b  = head1.data;
      if (!wide) begin
         word_ok   = have1;
         pop_n     = 2'd1;
         lane_data = early_b;
         lane_code = NARROW_FILL;
      end else begin
         if (head0.last) begin
            late_b  = PAD_BYTE;
            word_ok = have1;
            pop_n   = 2'd1;
         end else begin
            word_ok = have2;
            pop_n   = 2'd2;
         end
         lane_data = code_first ? late_b  : early_b;
         lane_code = code_first ? early_b : late_b;
      end
   end

endmodule

// File: rtl/cdx_lane_unpack.sv
module cdx_lane_unpack (
   input  logic       wide,
   input  logic       code_first,
   input  logic [7:0] lane_data,
   input  logic [7:0] lane_code,
   output logic [7:0] first_byte,
   output logic [7:0] second_byte,
   output logic [1:0] byte_n
);

   always_comb begin
      first_byte  = (wide && code_first) ? lane_code : lane_data;
      second_byte = code_first ? lane_data : lane_code;
      byte_n      = wide ? 2'd2 : 2'd1;
   end

endmodule

// File: rtl/cdx_width_adapter.sv
module cdx_width_adapter
   import cdx_pkg::*;
#(
   parameter int         DEPTH    = 8,
   parameter logic [7:0] PAD_BYTE = 8'hFF,
   localparam int        CW       = $clog2(DEPTH + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_decode,
   input  logic       cfg_wide,
   input  logic       cfg_code_first,
   input  logic       host_rd,
   input  logic       host_wr,
   input  logic [7:0] host_data_in,
   input  logic [7:0] host_code_in,
   output logic [7:0] host_data_out,
   output logic [7:0] host_code_out,
   input  logic       core_in_valid,
   output logic       core_in_ready,
   input  logic [7:0] core_in_byte,
   input  logic       core_in_last,
   output logic       core_out_valid,
   input  logic       core_out_ready,
   output logic [7:0] core_out_byte,
   input  logic       core_out_end,
   output logic       err_underrun,
   output logic       err_overrun
);

   cdx_dir_e      dir;
   cdx_entry_t    head0, head1, push0, push1;
   logic [CW-1:0] count, space;
   logic [1:0]    push_n, pop_n, pk_pop_n, up_n;
   logic          flush, have1, have2;
   logic          word_ok, rd_ok, rd_bad, wr_req, wr_ok, in_fire, out_fire;
   logic [7:0]    pk_data, pk_code, up_first, up_second;

   assign dir   = cdx_dir_e'(cfg_decode);
   assign have1 = count != '0;
   assign have2 = count >= CW'(2);
   assign space = CW'(DEPTH) - count;

   cdx_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_n (push_n),
      .push0  (push0),
      .push1  (push1),
      .pop_n  (pop_n),
      .flush  (flush),
      .head0  (head0),
      .head1  (head1),
      .count  (count)
   );

   cdx_lane_pack #(.PAD_BYTE(PAD_BYTE)) u_pack (
      .wide       (cfg_wide),
      .code_first (cfg_code_first),
      .head0      (head0),
      .head1      (head1),
      .have1      (have1),
      .have2      (have2),
      .word_ok    (word_ok),
      .pop_n      (pk_pop_n),
      .lane_data  (pk_data),
      .lane_code  (pk_code)
   );

   cdx_lane_unpack u_unpack (
      .wide        (cfg_wide),
      .code_first  (cfg_code_first),
      .lane_data   (host_data_in),
      .lane_code   (host_code_in),
      .first_byte  (up_first),
      .second_byte (up_second),
      .byte_n      (up_n)
   );

   // encode side
   assign core_in_ready = (dir == CDX_ENCODE) && (count < CW'(DEPTH));
   assign in_fire       = core_in_valid && core_in_ready;
   assign rd_ok         = (dir == CDX_ENCODE) && host_rd && word_ok;
   assign rd_bad        = (dir == CDX_ENCODE) && host_rd && !word_ok;

   // decode side
   assign core_out_valid = (dir == CDX_DECODE) && have1;
   assign core_out_byte  = head0.data;
   assign out_fire       = core_out_valid && core_out_ready;
   assign wr_req         = (dir == CDX_DECODE) && host_wr;
   assign wr_ok          = wr_req && (space >= CW'(up_n));
   assign flush          = out_fire && core_out_end;

   always_comb begin
      if (dir == CDX_ENCODE) begin
         push_n = in_fire ? 2'd1 : 2'd0;
         push0  = '{last: core_in_last, data: core_in_byte};
         push1  = '{last: 1'b0, data: 8'h00};
         pop_n  = rd_ok ? pk_pop_n : 2'd0;
      end else begin
         push_n = wr_ok ? up_n : 2'd0;
         push0  = '{last: 1'b0, data: up_first};
         push1  = '{last: 1'b0, data: up_second};
         pop_n  = out_fire ? 2'd1 : 2'd0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_data_out <= 8'h00;
         host_code_out <= 8'h00;
         err_underrun  <= 1'b0;
         err_overrun   <= 1'b0;
      end else begin
         if (rd_ok) begin
            host_data_out <= pk_data;
            host_code_out <= pk_code;
         end
         if (rd_bad)                 err_underrun <= 1'b1;
         if (wr_req && !wr_ok)       err_overrun  <= 1'b1;
      end
   end

   // R4: a lone tagged byte leaves the fill value on the other lane
   p_pad_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ok && cfg_wide && head0.last) |=>
         ((cfg_code_first ? host_data_out : host_code_out) == PAD_BYTE));

   // R5: an unserved read keeps the outputs and raises the flag
   p_underrun_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_bad |=> ($stable(host_data_out) && $stable(host_code_out) && err_underrun));

   // R8: flushing with no new write leaves nothing for the core
   p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !wr_ok) |=> !core_out_valid);

   // R9: the overrun flag never clears outside reset
   p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_overrun |=> err_overrun);

   // R11: reads in decode mode never change the host outputs
   p_ignore_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_decode |=> ($stable(host_data_out) && $stable(host_code_out)));

endmodule

// File: tb/cdx_width_adapter_tb.sv
module cdx_width_adapter_tb;

   localparam int DEPTH = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_decode = 1'b0, cfg_wide = 1'b0, cfg_code_first = 1'b0;
   logic       host_rd = 1'b0, host_wr = 1'b0;
   logic [7:0] host_data_in = 8'h00, host_code_in = 8'h00;
   logic [7:0] host_data_out, host_code_out;
   logic       core_in_valid = 1'b0, core_in_last = 1'b0;
   logic [7:0] core_in_byte = 8'h00;
   logic       core_in_ready;
   logic       core_out_valid, core_out_ready = 1'b0, core_out_end = 1'b0;
   logic [7:0] core_out_byte;
   logic       err_underrun, err_overrun;

   int    checks = 0, errors = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   cdx_width_adapter #(.DEPTH(DEPTH)) u_dut (.*);

   // ---------------- reference model ----------------
   logic [8:0] q[$];
   logic [7:0] m_data = 8'h00, m_code = 8'h00;
   bit         m_under = 1'b0, m_over = 1'b0;

   always @(posedge clk) begin
      int sz;
      logic [7:0] e, l;
      if (!rst_n) begin
         q.delete();
         m_data = 8'h00; m_code = 8'h00; m_under = 1'b0; m_over = 1'b0;
      end else if (!cfg_decode) begin
         sz = q.size();
         if (host_rd) begin
            if (sz >= 1 && (!cfg_wide || q[0][8] || sz >= 2)) begin
               e = q[0][7:0];
               if (!cfg_wide) begin
                  m_data = e; m_code = 8'h00;
                  void'(q.pop_front());
               end else begin
                  if (q[0][8]) begin
                     l = 8'hFF;
                     void'(q.pop_front());
                  end else begin
                     l = q[1][7:0];
                     void'(q.pop_front());
                     void'(q.pop_front());
                  end
                  m_data = cfg_code_first ? l : e;
                  m_code = cfg_code_first ? e : l;
               end
            end else begin
               m_under = 1'b1;
            end
         end
         if (core_in_valid && sz < DEPTH) q.push_back({core_in_last, core_in_byte});
      end else begin
         sz = q.size();
         if (sz > 0 && core_out_ready) begin
            void'(q.pop_front());
            if (core_out_end) q.delete();
         end
         if (host_wr) begin
            if (DEPTH - sz >= (cfg_wide ? 2 : 1)) begin
               q.push_back({1'b0, (cfg_wide && cfg_code_first) ? host_code_in : host_data_in});
               if (cfg_wide) q.push_back({1'b0, cfg_code_first ? host_data_in : host_code_in});
            end else begin
               m_over = 1'b1;
            end
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      bit bad;
      if (rst_n && !done) begin
         bad = 1'b0;
         checks++;
         if (core_in_ready !== (!cfg_decode && q.size() < DEPTH)) begin
            bad = 1'b1;
            $display("FAIL %s core_in_ready got %0b exp %0b", cur_req, core_in_ready, (!cfg_decode && q.size() < DEPTH));
         end
         if (core_out_valid !== (cfg_decode && q.size() > 0)) begin
            bad = 1'b1;
            $display("FAIL %s core_out_valid got %0b exp %0b", cur_req, core_out_valid, (cfg_decode && q.size() > 0));
         end else if (core_out_valid && core_out_byte !== q[0][7:0]) begin
            bad = 1'b1;
            $display("FAIL %s core_out_byte got %h exp %h", cur_req, core_out_byte, q[0][7:0]);
         end
         if (host_data_out !== m_data || host_code_out !== m_code) begin
            bad = 1'b1;
            $display("FAIL %s host lanes got %h/%h exp %h/%h", cur_req, host_data_out, host_code_out, m_data, m_code);
         end
         if (err_underrun !== m_under || err_overrun !== m_over) begin
            bad = 1'b1;
            $display("FAIL %s flags got %0b/%0b exp %0b/%0b", cur_req, err_underrun, err_overrun, m_under, m_over);
         end
         if (bad) errors++;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic chk(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic do_reset(input logic dec, input logic wide, input logic cf);
      rst_n = 1'b0;
      cfg_decode = dec; cfg_wide = wide; cfg_code_first = cf;
      step(); step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic push_core(input logic [7:0] b, input logic last);
      core_in_valid = 1'b1; core_in_byte = b; core_in_last = last;
      step();
      core_in_valid = 1'b0; core_in_last = 1'b0;
   endtask

   task automatic host_read();
      host_rd = 1'b1; step(); host_rd = 1'b0;
   endtask

   task automatic host_write(input logic [7:0] d, input logic [7:0] c);
      host_wr = 1'b1; host_data_in = d; host_code_in = c;
      step();
      host_wr = 1'b0;
   endtask

   task automatic core_take(input logic fin);
      core_out_ready = 1'b1; core_out_end = fin;
      step();
      core_out_ready = 1'b0; core_out_end = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired got running exp finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      step();
      // R1 reset state
      cur_req = "R1";
      do_reset(1'b0, 1'b0, 1'b0);
      chk("R1", "data lane", host_data_out, 8'h00);
      chk("R1", "code lane", host_code_out, 8'h00);
      chk("R1", "ready", {7'd0, core_in_ready}, 8'h01);
      chk("R1", "valid", {7'd0, core_out_valid}, 8'h00);
      chk("R1", "flags", {6'd0, err_underrun, err_overrun}, 8'h00);

      // R2 narrow encode
      cur_req = "R2";
      push_core(8'hA1, 1'b0); push_core(8'hA2, 1'b0); push_core(8'hA3, 1'b1);
      host_read(); chk("R2", "byte 1", host_data_out, 8'hA1);
      chk("R2", "code fill", host_code_out, 8'h00);
      host_read(); chk("R2", "byte 2", host_data_out, 8'hA2);
      host_read(); chk("R2", "byte 3", host_data_out, 8'hA3);

      // R3 wide encode, both orders
      cur_req = "R3";
      do_reset(1'b0, 1'b1, 1'b0);
      push_core(8'h11, 1'b0); push_core(8'h22, 1'b0); push_core(8'h33, 1'b0); push_core(8'h44, 1'b0);
      host_read();
      chk("R3", "order0 data", host_data_out, 8'h11);
      chk("R3", "order0 code", host_code_out, 8'h22);
      host_read();
      chk("R3", "order0 data 2", host_data_out, 8'h33);
      do_reset(1'b0, 1'b1, 1'b1);
      push_core(8'h55, 1'b0); push_core(8'h66, 1'b0);
      host_read();
      chk("R3", "order1 code", host_code_out, 8'h55);
      chk("R3", "order1 data", host_data_out, 8'h66);

      // R4 pad of lone final byte
      cur_req = "R4";
      do_reset(1'b0, 1'b1, 1'b0);
      push_core(8'h77, 1'b0); push_core(8'h88, 1'b0); push_core(8'h99, 1'b1); push_core(8'h5C, 1'b0);
      host_read();
      host_read();
      chk("R4", "last byte", host_data_out, 8'h99);
      chk("R4", "pad lane", host_code_out, 8'hFF);
      do_reset(1'b0, 1'b1, 1'b1);
      push_core(8'hC3, 1'b1);
      host_read();
      chk("R4", "order1 last", host_code_out, 8'hC3);
      chk("R4", "order1 pad", host_data_out, 8'hFF);

      // R5 underrun
      cur_req = "R5";
      do_reset(1'b0, 1'b1, 1'b0);
      push_core(8'h12, 1'b0);
      host_read();
      chk("R5", "flag", {7'd0, err_underrun}, 8'h01);
      chk("R5", "data kept", host_data_out, 8'h00);
      push_core(8'h34, 1'b0);
      host_read();
      chk("R5", "no loss data", host_data_out, 8'h12);
      chk("R5", "no loss code", host_code_out, 8'h34);
      chk("R5", "sticky", {7'd0, err_underrun}, 8'h01);

      // R10 full buffer backpressure
      cur_req = "R10";
      do_reset(1'b0, 1'b0, 1'b0);
      for (int i = 0; i < DEPTH + 1; i++) push_core(8'(8'h40 + i), 1'b0);
      chk("R10", "ready when full", {7'd0, core_in_ready}, 8'h00);
      host_read();
      chk("R10", "oldest out", host_data_out, 8'h40);
      chk("R10", "ready again", {7'd0, core_in_ready}, 8'h01);

      // R11 wrong-direction strobes
      cur_req = "R11";
      do_reset(1'b0, 1'b0, 1'b0);
      host_write(8'hDE, 8'hAD);
      host_read();
      chk("R11", "write ignored in encode", {7'd0, err_underrun}, 8'h01);
      do_reset(1'b1, 1'b0, 1'b0);
      host_read();
      chk("R11", "read ignored in decode", host_data_out, 8'h00);
      chk("R11", "no underrun in decode", {7'd0, err_underrun}, 8'h00);

      // R6 narrow decode
      cur_req = "R6";
      host_write(8'h5A, 8'hEE); host_write(8'h5B, 8'hEE);
      chk("R6", "first", core_out_byte, 8'h5A);
      core_take(1'b0);
      chk("R6", "second", core_out_byte, 8'h5B);
      core_take(1'b0);
      chk("R6", "code lane ignored", {7'd0, core_out_valid}, 8'h00);

      // R7 wide decode, both orders
      cur_req = "R7";
      do_reset(1'b1, 1'b1, 1'b0);
      host_write(8'h01, 8'h02);
      chk("R7", "order0 first", core_out_byte, 8'h01);
      core_take(1'b0);
      chk("R7", "order0 second", core_out_byte, 8'h02);
      do_reset(1'b1, 1'b1, 1'b1);
      host_write(8'h01, 8'h02);
      chk("R7", "order1 first", core_out_byte, 8'h02);
      core_take(1'b0);
      chk("R7", "order1 second", core_out_byte, 8'h01);

      // R8 filler dropped at stream end
      cur_req = "R8";
      do_reset(1'b1, 1'b1, 1'b0);
      host_write(8'hA0, 8'hA1); host_write(8'hA2, 8'h5E);
      core_take(1'b0); core_take(1'b0);
      chk("R8", "final byte", core_out_byte, 8'hA2);
      core_take(1'b1);
      chk("R8", "filler gone", {7'd0, core_out_valid}, 8'h00);

      // R9 overrun
      cur_req = "R9";
      do_reset(1'b1, 1'b1, 1'b0);
      for (int i = 0; i < DEPTH / 2; i++) host_write(8'(8'h10 + 2 * i), 8'(8'h11 + 2 * i));
      host_write(8'hEE, 8'hEE);
      chk("R9", "flag", {7'd0, err_overrun}, 8'h01);
      for (int i = 0; i < DEPTH; i++) begin
         chk("R9", "stored byte", core_out_byte, 8'(8'h10 + i));
         core_take(1'b0);
      end
      chk("R9", "nothing extra", {7'd0, core_out_valid}, 8'h00);

      // random mixed traffic, checked by the model every cycle
      cur_req = "R2/R3/R4 random";
      for (int m = 0; m < 4; m++) begin
         do_reset(1'b0, m[0], m[1]);
         for (int i = 0; i < 400; i++) begin
            core_in_valid = ($urandom % 2) == 0;
            core_in_byte  = 8'($urandom);
            core_in_last  = ($urandom % 6) == 0;
            host_rd       = ($urandom % 3) == 0;
            step();
         end
         core_in_valid = 1'b0; host_rd = 1'b0;
      end
      cur_req = "R6/R7/R8 random";
      for (int m = 0; m < 4; m++) begin
         do_reset(1'b1, m[0], m[1]);
         for (int i = 0; i < 400; i++) begin
            host_wr        = ($urandom % 3) == 0;
            host_data_in   = 8'($urandom);
            host_code_in   = 8'($urandom);
            core_out_ready = ($urandom % 2) == 0;
            core_out_end   = ($urandom % 9) == 0;
            step();
         end
         host_wr = 1'b0; core_out_ready = 1'b0; core_out_end = 1'b0;
      end

      step();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule